// File: doc/BRIEF.md
# Stack Frame Call/Return Sequencer

This block carries out the stack side of four control operations for a word-addressed processor: pushing a word, popping a word, calling a subroutine and returning from one. It owns the stack pointer, the frame pointer and the program counter. It reaches memory through one single-port synchronous word memory, making at most one request per cycle. Read data comes back on the cycle after the request.

The stack grows toward lower addresses. A push stores at the current stack pointer and then steps the pointer down. A pop steps the pointer up first and then reads. A call saves the return address and then the old frame pointer. Only after both are saved does the frame pointer take the stack pointer's value, and then the program counter jumps to the target. A return first moves the stack pointer back to the frame pointer, then reloads the frame pointer, then reloads the program counter.

A call may be made conditional. When the supplied condition input is false, the call touches nothing except the program counter, which advances as for an ordinary instruction. The decoder upstream issues each operation as a one-cycle start strobe, and the block answers with a busy level and a done pulse.

Top module: `stk_frame_seq`

## Requirements
- R1: A synchronous reset puts the block in idle with busy and done low, both stack pointer and frame pointer equal to the `TOS_ADDR` parameter, and the program counter equal to `RESET_PC`.
- R2: A push (op_sel = 0) writes its word to memory at the current stack pointer, then lowers the stack pointer by one and raises the program counter by one.
- R3: With push_lit = 1, a push stores lit_a sign-extended from 40 bits to the 64-bit word instead of push_val.
- R4: A pop (op_sel = 1) raises the stack pointer by one, reads the word at the new stack pointer, and advances the program counter. When pop_keep is 1 it presents the word on pop_data with a one-cycle pop_wr pulse. When pop_keep is 0 pop_wr stays low and pop_data keeps its old value.
- R5: A call (op_sel = 2) writes the program counter plus one at the stack pointer, then writes the old frame pointer one word lower. It then sets the frame pointer to the resulting stack pointer (two below its start) and loads the program counter with the target.
- R6: tgt_sel selects the call target: 0 addr_reg; 1 lit_a sign-extended; 2 addr_reg plus sign-extended lit_a; 3 the sum of sign-extended lit_a and lit_b; 4 addr_reg plus int_reg. All sums are taken modulo 2^AW.
- R7: A call with cond_en = 1 and cond_met = 0 makes no memory request and leaves the stack and frame pointers unchanged. It advances the program counter by one and raises done after the start edge without raising busy.
- R8: A return (op_sel = 3) copies the frame pointer into the stack pointer. It then reads the frame pointer from the stack pointer plus one, and the program counter from the stack pointer plus two. The stack pointer ends two above the old frame pointer.
- R9: A start strobe that arrives while busy is high is ignored.
- R10: done is a one-cycle pulse raised only when busy is low, and mem_req is raised only while busy is high.
- R11: Busy lasts 1 cycle for a push, 2 for a pop, 3 for a call (two writes plus one update) and 4 for a return (one update plus two reads plus one capture).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle strobe that begins an operation |
| op_sel | input | 2 | 0 push, 1 pop, 2 call, 3 return |
| push_lit | input | 1 | Push stores sign-extended lit_a instead of push_val |
| pop_keep | input | 1 | Pop delivers its word to pop_data |
| cond_en | input | 1 | Call is conditional |
| cond_met | input | 1 | Condition result for a conditional call |
| tgt_sel | input | 3 | Call target form |
| addr_reg | input | AW | Address register operand |
| int_reg | input | DW | Integer register operand |
| lit_a | input | LW | First signed literal |
| lit_b | input | LW | Second signed literal |
| push_val | input | DW | Register word to push |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_o | output | AW | Stack pointer |
| fp_o | output | AW | Frame pointer |
| pc_o | output | AW | Program counter |
| pop_wr | output | 1 | Pop result strobe |
| pop_data | output | DW | Pop result word |

## Verification
The properties assume that reset is held high on the first clock edge. They also assume every input is driven to a known value at each edge, and that the memory returns read data exactly one cycle after a read request. The bench asserts reset from time zero and drives every input on falling edges. Its memory model answers reads on the next rising edge. Start strobes during busy carry deliberately corrupted fields, which tests the rule that such strobes are ignored without disturbing the sequence in progress.

// File: rtl/stk_pkg.sv
package stk_pkg;

   typedef enum logic [1:0] {
      OP_PUSH = 2'd0,
      OP_POP  = 2'd1,
      OP_CALL = 2'd2,
      OP_RET  = 2'd3
   } stk_op_e;

   typedef enum logic [2:0] {
      TG_REG     = 3'd0,
      TG_LIT     = 3'd1,
      TG_REG_LIT = 3'd2,
      TG_LIT_LIT = 3'd3,
      TG_REG_REG = 3'd4
   } stk_tgt_e;

   typedef enum logic [3:0] {
      ST_IDLE     = 4'd0,
      ST_PUSH_WR  = 4'd1,
      ST_POP_RD   = 4'd2,
      ST_POP_CAP  = 4'd3,
      ST_CALL_RA  = 4'd4,
      ST_CALL_FP  = 4'd5,
      ST_CALL_SET = 4'd6,
      ST_RET_SP   = 4'd7,
      ST_RET_RD1  = 4'd8,
      ST_RET_RD2  = 4'd9,
      ST_RET_FIN  = 4'd10
   } stk_state_e;

endpackage

// File: rtl/stk_tgt_gen.sv
module stk_tgt_gen #(
   parameter int AW = 10,
   parameter int DW = 64,
   parameter int LW = 40
) (
   input  logic [2:0]    tgt_sel,
   input  logic [AW-1:0] addr_reg,
   input  logic [DW-1:0] int_reg,
   input  logic [LW-1:0] lit_a,
   input  logic [LW-1:0] lit_b,
   output logic [AW-1:0] tgt,
   output logic [DW-1:0] lit_word
);
   import stk_pkg::*;

   localparam int WEXT = DW - LW;

   logic [AW-1:0] lit_a_aw;
   logic [AW-1:0] lit_b_aw;
   logic [AW-1:0] int_aw;

   // Literal narrowed or widened to the address width
   generate
      if (LW >= AW) begin : g_lit_trunc
         assign lit_a_aw = lit_a[AW-1:0];
         assign lit_b_aw = lit_b[AW-1:0];
      end else begin : g_lit_sext
         assign lit_a_aw = {{(AW-LW){lit_a[LW-1]}}, lit_a};
         assign lit_b_aw = {{(AW-LW){lit_b[LW-1]}}, lit_b};
      end

      if (WEXT > 0) begin : g_word_sext
         assign lit_word = {{WEXT{lit_a[LW-1]}}, lit_a};
      end else begin : g_word_same
         assign lit_word = lit_a;
      end
   endgenerate

   assign int_aw = int_reg[AW-1:0];

   always_comb begin
      unique case (tgt_sel)
         TG_REG:     tgt = addr_reg;
         TG_LIT:     tgt = lit_a_aw;
         TG_REG_LIT: tgt = addr_reg + lit_a_aw;
         TG_LIT_LIT: tgt = lit_a_aw + lit_b_aw;
         TG_REG_REG: tgt = addr_reg + int_aw;
         default:    tgt = addr_reg;
      endcase
   end

endmodule

// File: rtl/stk_seq_fsm.sv
module stk_seq_fsm (
   input  logic                clk,
   input  logic                rst,
   input  logic                start,
   input  logic [1:0]          op_sel,
   input  logic                cond_en,
   input  logic                cond_met,
   output stk_pkg::stk_state_e state,
   output logic                accept,
   output logic                skip,
   output logic                finish
);
   import stk_pkg::*;

   stk_state_e nxt;

   assign accept = (state == ST_IDLE) && start;
   assign skip   = accept && (op_sel == OP_CALL) && cond_en && !cond_met;

   always_comb begin
      unique case (state)
         ST_PUSH_WR, ST_POP_CAP, ST_CALL_SET, ST_RET_FIN: finish = 1'b1;
         default: finish = skip;
      endcase
   end

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: begin
            if (accept) begin
               unique case (op_sel)
                  OP_PUSH: nxt = ST_PUSH_WR;
                  OP_POP:  nxt = ST_POP_RD;
                  OP_CALL: nxt = skip ? ST_IDLE : ST_CALL_RA;
                  default: nxt = ST_RET_SP;
               endcase
            end
         end
         ST_PUSH_WR:  nxt = ST_IDLE;
         ST_POP_RD:   nxt = ST_POP_CAP;
         ST_POP_CAP:  nxt = ST_IDLE;
         ST_CALL_RA:  nxt = ST_CALL_FP;
         ST_CALL_FP:  nxt = ST_CALL_SET;
         ST_CALL_SET: nxt = ST_IDLE;
         ST_RET_SP:   nxt = ST_RET_RD1;
         ST_RET_RD1:  nxt = ST_RET_RD2;
         ST_RET_RD2:  nxt = ST_RET_FIN;
         ST_RET_FIN:  nxt = ST_IDLE;
         default:     nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_IDLE;
      else     state <= nxt;
   end

endmodule

// File: rtl/stk_mem_port.sv
module stk_mem_port #(
   parameter int AW = 10,
   parameter int DW = 64
) (
   input  stk_pkg::stk_state_e state,
   input  logic [AW-1:0]       sp,
   input  logic [AW-1:0]       fp,
   input  logic [AW-1:0]       pc,
   input  logic [DW-1:0]       push_word,
   output logic                mem_req,
   output logic                mem_we,
   output logic [AW-1:0]       mem_addr,
   output logic [DW-1:0]       mem_wdata
);
   import stk_pkg::*;

   logic [AW-1:0] sp_up;
   logic [AW-1:0] ret_addr;

   assign sp_up    = sp + 1'b1;
   assign ret_addr = pc + 1'b1;

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = sp;
      mem_wdata = '0;
      unique case (state)
         ST_PUSH_WR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = push_word;
         end
         ST_CALL_RA: begin
            mem_req              = 1'b1;
            mem_we               = 1'b1;
            mem_wdata[AW-1:0]    = ret_addr;
         end
         ST_CALL_FP: begin
            mem_req              = 1'b1;
            mem_we               = 1'b1;
            mem_wdata[AW-1:0]    = fp;
         end
         ST_POP_RD, ST_RET_RD1, ST_RET_RD2: begin
            mem_req  = 1'b1;
            mem_addr = sp_up;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/stk_frame_seq.sv
module stk_frame_seq #(
   parameter int              AW       = 10,
   parameter int              DW       = 64,
   parameter int              LW       = 40,
   parameter logic [63:0]     TOS_ADDR = 64'h3F0,
   parameter logic [63:0]     RESET_PC = 64'h0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic [1:0]    op_sel,
   input  logic          push_lit,
   input  logic          pop_keep,
   input  logic          cond_en,
   input  logic          cond_met,
   input  logic [2:0]    tgt_sel,
   input  logic [AW-1:0] addr_reg,
   input  logic [DW-1:0] int_reg,
   input  logic [LW-1:0] lit_a,
   input  logic [LW-1:0] lit_b,
   input  logic [DW-1:0] push_val,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          busy,
   output logic          done,
   output logic [AW-1:0] sp_o,
   output logic [AW-1:0] fp_o,
   output logic [AW-1:0] pc_o,
   output logic          pop_wr,
   output logic [DW-1:0] pop_data
);
   import stk_pkg::*;

   localparam logic [AW-1:0] TOS_INIT = TOS_ADDR[AW-1:0];
   localparam logic [AW-1:0] PC_INIT  = RESET_PC[AW-1:0];

   generate
      if (AW < 2 || AW > DW) begin : g_bad_aw
         $error("stk_frame_seq: AW must lie in 2..DW");
      end
      if (LW < 2 || LW > DW) begin : g_bad_lw
         $error("stk_frame_seq: LW must lie in 2..DW");
      end
      if (AW < 64) begin : g_chk_tos
         if ((TOS_ADDR >> AW) != 64'd0) begin : g_bad_tos
            $error("stk_frame_seq: TOS_ADDR exceeds address width");
         end
      end
   endgenerate

   stk_state_e    state;
   logic          accept;
   logic          skip;
   logic          finish;
   logic [AW-1:0] tgt;
   logic [DW-1:0] lit_word;

   logic [AW-1:0] sp_q;
   logic [AW-1:0] fp_q;
   logic [AW-1:0] pc_q;
   logic [AW-1:0] tgt_q;
   logic [DW-1:0] push_q;
   logic          keep_q;

   stk_seq_fsm u_fsm (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .op_sel   (op_sel),
      .cond_en  (cond_en),
      .cond_met (cond_met),
      .state    (state),
      .accept   (accept),
      .skip     (skip),
      .finish   (finish)
   );

   stk_tgt_gen #(.AW(AW), .DW(DW), .LW(LW)) u_tgt (
      .tgt_sel  (tgt_sel),
      .addr_reg (addr_reg),
      .int_reg  (int_reg),
      .lit_a    (lit_a),
      .lit_b    (lit_b),
      .tgt      (tgt),
      .lit_word (lit_word)
   );

   stk_mem_port #(.AW(AW), .DW(DW)) u_mem (
      .state     (state),
      .sp        (sp_q),
      .fp        (fp_q),
      .pc        (pc_q),
      .push_word (push_q),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );

   // Operand capture at the accepting edge
   always_ff @(posedge clk) begin
      if (rst) begin
         tgt_q  <= '0;
         push_q <= '0;
         keep_q <= 1'b0;
      end else if (accept) begin
         tgt_q  <= tgt;
         push_q <= push_lit ? lit_word : push_val;
         keep_q <= pop_keep;
      end
   end

   // Architectural pointer updates, one step per state
   always_ff @(posedge clk) begin
      if (rst) begin
         sp_q     <= TOS_INIT;
         fp_q     <= TOS_INIT;
         pc_q     <= PC_INIT;
         done     <= 1'b0;
         pop_wr   <= 1'b0;
         pop_data <= '0;
      end else begin
         done   <= finish;
         pop_wr <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (skip) pc_q <= pc_q + 1'b1;
            end
            ST_PUSH_WR: begin
               sp_q <= sp_q - 1'b1;
               pc_q <= pc_q + 1'b1;
            end
            ST_POP_RD: sp_q <= sp_q + 1'b1;
            ST_POP_CAP: begin
               if (keep_q) pop_data <= mem_rdata;
               pop_wr <= keep_q;
               pc_q   <= pc_q + 1'b1;
            end
            ST_CALL_RA, ST_CALL_FP: sp_q <= sp_q - 1'b1;
            ST_CALL_SET: begin
               fp_q <= sp_q;
               pc_q <= tgt_q;
            end
            ST_RET_SP:  sp_q <= fp_q;
            ST_RET_RD1: sp_q <= sp_q + 1'b1;
            ST_RET_RD2: begin
               fp_q <= mem_rdata[AW-1:0];
               sp_q <= sp_q + 1'b1;
            end
            ST_RET_FIN: pc_q <= mem_rdata[AW-1:0];
            default: ;
         endcase
      end
   end

   assign busy = (state != ST_IDLE);
   assign sp_o = sp_q;
   assign fp_o = fp_q;
   assign pc_o = pc_q;

endmodule

// File: rtl/stk_frame_seq_chk.sv
module stk_frame_seq_chk #(
   parameter int          AW       = 10,
   parameter logic [63:0] TOS_ADDR = 64'h3F0,
   parameter logic [63:0] RESET_PC = 64'h0
) (
   input logic          clk,
   input logic          rst,
   input logic          start,
   input logic [1:0]    op_sel,
   input logic          cond_en,
   input logic          cond_met,
   input logic          busy,
   input logic          done,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [AW-1:0] sp_o,
   input logic [AW-1:0] fp_o,
   input logic [AW-1:0] pc_o
);

   p_reset_state_r1: assert property (@(posedge clk)
      rst |=> (!busy && !done && sp_o == TOS_ADDR[AW-1:0] &&
               fp_o == TOS_ADDR[AW-1:0] && pc_o == RESET_PC[AW-1:0]));

   p_wr_at_sp_r2: assert property (@(posedge clk) disable iff (rst)
      (mem_req && mem_we) |-> (mem_addr == sp_o));

   p_wr_step_down_r5: assert property (@(posedge clk) disable iff (rst)
      (mem_req && mem_we) |=> (sp_o == AW'($past(sp_o) - 1'b1)));

   p_rd_pre_inc_r4: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_we) |-> (mem_addr == AW'(sp_o + 1'b1)));

   p_rd_step_up_r8: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_we) |=> (sp_o == AW'($past(sp_o) + 1'b1)));

   p_cond_skip_r7: assert property (@(posedge clk) disable iff (rst)
      (!busy && start && op_sel == 2'd2 && cond_en && !cond_met) |=>
      (done && !busy && sp_o == $past(sp_o) && fp_o == $past(fp_o) &&
       pc_o == AW'($past(pc_o) + 1'b1)));

   p_ret_sp_from_fp_r8: assert property (@(posedge clk) disable iff (rst)
      (!busy && start && op_sel == 2'd3) |=> ##1 (sp_o == $past(fp_o, 2)));

   p_done_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);

   p_req_only_busy_r10: assert property (@(posedge clk) disable iff (rst)
      mem_req |-> busy);

endmodule

bind stk_frame_seq stk_frame_seq_chk #(
   .AW(AW), .TOS_ADDR(TOS_ADDR), .RESET_PC(RESET_PC)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .start    (start),
   .op_sel   (op_sel),
   .cond_en  (cond_en),
   .cond_met (cond_met),
   .busy     (busy),
   .done     (done),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .sp_o     (sp_o),
   .fp_o     (fp_o),
   .pc_o     (pc_o)
);

// File: tb/stk_frame_seq_tb_top.sv
`timescale 1ns/1ps
module stk_frame_seq_tb_top;
   localparam int AW = 10;
   localparam int DW = 64;
   localparam int LW = 40;
   localparam int MW = 1 << AW;
   localparam logic [AW-1:0] TOS = 10'h3F0;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic [1:0]    op_sel = '0;
   logic          push_lit = 1'b0;
   logic          pop_keep = 1'b0;
   logic          cond_en = 1'b0;
   logic          cond_met = 1'b0;
   logic [2:0]    tgt_sel = '0;
   logic [AW-1:0] addr_reg = '0;
   logic [DW-1:0] int_reg = '0;
   logic [LW-1:0] lit_a = '0;
   logic [LW-1:0] lit_b = '0;
   logic [DW-1:0] push_val = '0;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          busy, done, pop_wr;
   logic [AW-1:0] sp_o, fp_o, pc_o;
   logic [DW-1:0] pop_data;

   always #2.5 clk = ~clk;

   stk_frame_seq #(.AW(AW), .DW(DW), .LW(LW), .TOS_ADDR(64'h3F0), .RESET_PC(64'h0)) dut_i (
      .clk(clk), .rst(rst), .start(start), .op_sel(op_sel), .push_lit(push_lit),
      .pop_keep(pop_keep), .cond_en(cond_en), .cond_met(cond_met), .tgt_sel(tgt_sel),
      .addr_reg(addr_reg), .int_reg(int_reg), .lit_a(lit_a), .lit_b(lit_b),
      .push_val(push_val), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
      .sp_o(sp_o), .fp_o(fp_o), .pc_o(pc_o), .pop_wr(pop_wr), .pop_data(pop_data)
   );

   logic [DW-1:0] mem     [MW];
   logic [DW-1:0] exp_mem [MW];

   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) mem[mem_addr] <= mem_wdata;
         else        mem_rdata     <= mem[mem_addr];
      end
   end

   int n_run = 0;
   int n_fail = 0;
   logic [AW-1:0] m_sp, m_fp, m_pc;
   logic [DW-1:0] m_pop;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] sx(input logic [LW-1:0] v);
      return {{(64-LW){v[LW-1]}}, v};
   endfunction

   function automatic logic [AW-1:0] tgt_of(input logic [2:0] m, input logic [AW-1:0] a,
                                             input logic [DW-1:0] r, input logic [LW-1:0] la,
                                             input logic [LW-1:0] lb);
      logic [63:0] ea, eb;
      ea = sx(la);
      eb = sx(lb);
      case (m)
         3'd0: return a;
         3'd1: return ea[AW-1:0];
         3'd2: return a + ea[AW-1:0];
         3'd3: return ea[AW-1:0] + eb[AW-1:0];
         3'd4: return a + r[AW-1:0];
         default: return a;
      endcase
   endfunction

   task automatic model_reset();
      m_sp = TOS; m_fp = TOS; m_pc = '0; m_pop = '0;
   endtask

   // Issue one operation; hold keeps start high with corrupted fields while busy.
   task automatic do_op(input logic [1:0] op, input bit lit, input bit keep, input bit cen,
                        input bit cmet, input logic [2:0] ts, input logic [AW-1:0] ar,
                        input logic [DW-1:0] ir, input logic [LW-1:0] la, input logic [LW-1:0] lb,
                        input logic [DW-1:0] pv, input bit hold);
      int ncyc, n;
      bit skipped, saw_req;
      logic [AW-1:0] wa0, wa1;
      logic [DW-1:0] w;
      @(negedge clk);
      op_sel = op; push_lit = lit; pop_keep = keep; cond_en = cen; cond_met = cmet;
      tgt_sel = ts; addr_reg = ar; int_reg = ir; lit_a = la; lit_b = lb; push_val = pv;
      start = 1'b1;
      skipped = 1'b0; wa0 = '0; wa1 = '0;
      case (op)
         2'd0: begin
            w = lit ? sx(la) : pv;
            exp_mem[m_sp] = w; wa0 = m_sp; wa1 = m_sp;
            m_sp = m_sp - 1'b1; m_pc = m_pc + 1'b1; ncyc = 2;
         end
         2'd1: begin
            m_sp = m_sp + 1'b1;
            if (keep) m_pop = exp_mem[m_sp];
            m_pc = m_pc + 1'b1; ncyc = 3;
         end
         2'd2: begin
            if (cen && !cmet) begin
               skipped = 1'b1; m_pc = m_pc + 1'b1; ncyc = 1;
            end else begin
               exp_mem[m_sp] = {{(DW-AW){1'b0}}, m_pc + 1'b1}; wa0 = m_sp;
               m_sp = m_sp - 1'b1;
               exp_mem[m_sp] = {{(DW-AW){1'b0}}, m_fp}; wa1 = m_sp;
               m_sp = m_sp - 1'b1;
               m_fp = m_sp;
               m_pc = tgt_of(ts, ar, ir, la, lb); ncyc = 4;
            end
         end
         default: begin
            m_sp = m_fp;
            m_sp = m_sp + 1'b1; m_fp = exp_mem[m_sp][AW-1:0];
            m_sp = m_sp + 1'b1; m_pc = exp_mem[m_sp][AW-1:0];
            ncyc = 5;
         end
      endcase
      @(negedge clk);
      saw_req = mem_req;
      if (hold && !skipped) begin
         op_sel = 2'd0; push_lit = 1'b0; push_val = 64'hBAD0_BAD0_BAD0_BAD0;
         tgt_sel = 3'd1; lit_a = 40'h12345;
      end else begin
         start = 1'b0;
      end
      n = 1;
      while (!done && n < 12) begin
         @(negedge clk);
         n++;
      end
      start = 1'b0;
      chk(n == ncyc, "R11 busy length", n, ncyc);
      chk(!busy, "R10 done only when idle", busy, 0);
      chk(sp_o == m_sp, hold ? "R9 sp after ignored start" : "R2/R4/R5/R8 sp", sp_o, m_sp);
      chk(fp_o == m_fp, hold ? "R9 fp after ignored start" : "R5/R8 fp", fp_o, m_fp);
      chk(pc_o == m_pc, (op == 2'd2) ? "R6 pc target" : "R8 pc", pc_o, m_pc);
      if (skipped) begin
         chk(!saw_req, "R7 no memory request on false condition", saw_req, 0);
      end
      if (op == 2'd1) begin
         chk(pop_wr == keep, "R4 pop_wr follows pop_keep", pop_wr, keep);
         chk(pop_data == m_pop, "R4 pop_data", pop_data, m_pop);
      end
      if (op == 2'd0) begin
         chk(mem[wa0] == exp_mem[wa0], lit ? "R3 literal word stored" : "R2 pushed word", mem[wa0], exp_mem[wa0]);
      end
      if (op == 2'd2 && !skipped) begin
         chk(mem[wa0] == exp_mem[wa0], "R5 return address saved", mem[wa0], exp_mem[wa0]);
         chk(mem[wa1] == exp_mem[wa1], "R5 old frame saved", mem[wa1], exp_mem[wa1]);
      end
      @(negedge clk);
      chk(!done && !pop_wr, "R10 single-cycle done", done, 0);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      model_reset();
      chk(!busy && !done, "R1 idle after reset", {busy, done}, 0);
      chk(sp_o == TOS && fp_o == TOS, "R1 pointers at top", {sp_o, fp_o}, {TOS, TOS});
      chk(pc_o == '0, "R1 pc at reset value", pc_o, 0);
   endtask

   bit finished = 1'b0;

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED));
      for (int i = 0; i < MW; i++) begin
         mem[i] = '0;
         exp_mem[i] = '0;
      end
      model_reset();
      @(negedge clk);
      do_reset();

      // Directed corner cases
      do_op(2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 64'hDEAD_BEEF_0123_4567, 0);
      do_op(2'd0, 1, 0, 0, 0, 0, 0, 0, 40'h80_0000_0001, 0, 0, 0);
      do_op(2'd0, 1, 0, 0, 0, 0, 0, 0, 40'h7F_FFFF_FFFF, 0, 0, 0);
      do_op(2'd1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      do_op(2'd1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      do_op(2'd2, 0, 0, 0, 0, 3'd0, 10'h100, 0, 0, 0, 0, 0);
      do_op(2'd2, 0, 0, 0, 0, 3'd1, 0, 0, 40'hFF_FFFF_FFF0, 0, 0, 0);
      do_op(2'd2, 0, 0, 1, 1, 3'd2, 10'h200, 0, 40'hFF_FFFF_FFFE, 0, 0, 0);
      do_op(2'd2, 0, 0, 1, 0, 3'd2, 10'h080, 0, 40'h5, 0, 0, 0);
      do_op(2'd2, 0, 0, 0, 0, 3'd3, 0, 0, 40'h40, 40'hFF_FFFF_FFFF, 0, 0);
      do_op(2'd2, 0, 0, 0, 0, 3'd4, 10'h3FF, 64'h2, 0, 0, 0, 1);
      do_op(2'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      do_op(2'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      do_op(2'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      do_op(2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 64'h1111, 1);

      // Constrained random traffic
      for (int k = 0; k < 300; k++) begin
         logic [1:0] op;
         op = 2'($urandom_range(0, 3));
         do_op(op, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               3'($urandom_range(0, 4)), AW'($urandom), {$urandom, $urandom},
               {8'($urandom), $urandom}, {8'($urandom), $urandom},
               {$urandom, $urandom}, ($urandom_range(0, 3) == 0));
      end

      do_reset();
      do_op(2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 64'h77, 0);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule